// File: doc/BRIEF.md
# Configurable Registered I/O Output Cell

This block is the output stage that sits behind one OR sum of a programmable sum-of-products array. It holds one D flip-flop. It also has two selection paths: one picks what the pin drives, the other picks what goes back into the array. Four configuration bits and a mode input set the cell. The cell can be registered or combinational, active-high or active-low, and it can feed back the flip-flop state, the raw OR sum or the pin value.

All cells of an array share one clock term, one synchronous preset term and one asynchronous clear term. Each cell also receives its own output-enable term, which it passes to the pin buffer. There are two modes. In compatibility mode the feedback path follows the output type, which leaves four configurations. In extended mode the feedback path is chosen on its own, which gives twelve configurations (two polarities, two output types and three feedback sources).

Top module: `pld_io_cell`

## Requirements
- R1: While `async_clear` is 1, the stored state reads 0 at once, without waiting for a clock edge. It overrides `sync_preset` and `rst`.
- R2: With `async_clear` at 0, `rst` at 1 clears the stored state on the next rising edge of `clk`.
- R3: With `async_clear` and `rst` at 0, `sync_preset` at 1 sets the stored state to 1 on the next edge, whatever `or_sum` is.
- R4: With `async_clear`, `rst` and `sync_preset` all at 0, the stored state takes `or_sum` on every rising edge.
- R5: `cfg_bits[1]` selects the output type. 1 drives the pin from the stored state. 0 drives it from `or_sum` in the same cycle.
- R6: `cfg_bits[0]` selects the polarity. 1 passes the selected value unchanged to `pin_out`. 0 inverts it. The inversion is applied after the type selection.
- R7: `pin_oe` equals `oe_term` in the same cycle, in every configuration and mode.
- R8: When `ext_mode` is 1, `cfg_bits[3:2]` selects `fb_out` as follows: 00 gives the stored state, 01 gives `or_sum`, and 10 or 11 gives `pin_in`. Polarity never inverts the feedback.
- R9: When `ext_mode` is 0, `cfg_bits[3:2]` has no effect. `fb_out` is the stored state when `cfg_bits[1]` is 1, and `pin_in` when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock term |
| rst | input | 1 | Synchronous active-high reset of the stored state |
| ext_mode | input | 1 | 1 = extended twelve-configuration mode, 0 = compatibility mode |
| cfg_bits | input | 4 | Cell configuration: [0] polarity, [1] output type, [3:2] feedback source |
| or_sum | input | 1 | OR of this cell's product terms |
| oe_term | input | 1 | Output-enable product term |
| sync_preset | input | 1 | Shared synchronous preset term |
| async_clear | input | 1 | Shared asynchronous clear term |
| pin_in | input | 1 | Value currently present on the pin |
| pin_out | output | 1 | Value the pin buffer drives |
| pin_oe | output | 1 | Tristate enable for the pin buffer |
| fb_out | output | 1 | Feedback signal returned to the array |

## Verification
The bench runs through all sixteen codes of `cfg_bits` in both modes. Each code is exercised with clear, preset and ordinary loads, and with `pin_in` moved against `or_sum`. A design that inverted the feedback, or that honoured the feedback bits in compatibility mode, would then show a wrong `fb_out`. A design that applied polarity before the type selection would give a wrong `pin_out` in the registered active-low codes. A design that only sampled the clear on a clock edge, or that ranked the preset above the clear, would show a 1 on a registered pin during the cycle the clear is raised together with the preset. Code 11 of the feedback field is also checked, so a design that returned 0 or the stored state there would fail.

// File: rtl/pld_cell_pkg.sv
package pld_cell_pkg;

    parameter int CFG_WIDTH = 4;
    localparam int FB_SEL_WIDTH = CFG_WIDTH - 2;

    typedef enum logic [FB_SEL_WIDTH-1:0] {
        FB_STATE   = 2'b00,
        FB_SUM     = 2'b01,
        FB_PIN     = 2'b10,
        FB_PIN_ALT = 2'b11
    } fb_src_e;

    typedef struct packed {
        fb_src_e fb_src;
        logic    registered;
        logic    active_high;
    } cell_cfg_t;

    function automatic cell_cfg_t decode_cfg(input logic [CFG_WIDTH-1:0] bits,
                                             input logic ext);
        cell_cfg_t c;
        c.active_high = bits[0];
        c.registered  = bits[1];
        if (ext) begin
            c.fb_src = fb_src_e'(bits[CFG_WIDTH-1:2]);
        end else begin
            c.fb_src = bits[1] ? FB_STATE : FB_PIN;
        end
        return c;
    endfunction

endpackage

// File: rtl/pld_cell_state.sv
module pld_cell_state (
    input  logic clk,
    input  logic rst,
    input  logic async_clear,
    input  logic sync_preset,
    input  logic d,
    output logic q
);

    always_ff @(posedge clk or posedge async_clear) begin
        if (async_clear) begin
            q <= 1'b0;
        end else if (rst) begin
            q <= 1'b0;
        end else if (sync_preset) begin
            q <= 1'b1;
        end else begin
            q <= d;
        end
    end

    AST_CLEAR_FORCES_ZERO: assert property (@(posedge clk) disable iff (rst)
        async_clear |-> !q); // R1

    AST_PRESET_SETS_ONE: assert property (@(posedge clk) disable iff (rst || async_clear)
        sync_preset |=> q); // R3

    AST_LOADS_SUM: assert property (@(posedge clk) disable iff (rst || async_clear)
        !sync_preset |=> q == $past(d)); // R4

endmodule

// File: rtl/pld_cell_out_path.sv
module pld_cell_out_path
    import pld_cell_pkg::*;
(
    input  cell_cfg_t cfg,
    input  logic      q,
    input  logic      or_sum,
    output logic      pin_out
);

    logic chosen;

    always_comb begin
        chosen  = cfg.registered ? q : or_sum;
        pin_out = cfg.active_high ? chosen : ~chosen;
    end

endmodule

// File: rtl/pld_cell_fb_path.sv
module pld_cell_fb_path
    import pld_cell_pkg::*;
(
    input  cell_cfg_t cfg,
    input  logic      q,
    input  logic      or_sum,
    input  logic      pin_in,
    output logic      fb_out
);

    always_comb begin
        unique case (cfg.fb_src)
            FB_STATE:   fb_out = q;
            FB_SUM:     fb_out = or_sum;
            FB_PIN:     fb_out = pin_in;
            FB_PIN_ALT: fb_out = pin_in;
            default:    fb_out = pin_in;
        endcase
    end

endmodule

// File: rtl/pld_io_cell.sv
module pld_io_cell
    import pld_cell_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ext_mode,
    input  logic [CFG_WIDTH-1:0] cfg_bits,
    input  logic                 or_sum,
    input  logic                 oe_term,
    input  logic                 sync_preset,
    input  logic                 async_clear,
    input  logic                 pin_in,
    output logic                 pin_out,
    output logic                 pin_oe,
    output logic                 fb_out
);

    cell_cfg_t cfg;
    logic      q;

    assign cfg    = decode_cfg(cfg_bits, ext_mode);
    assign pin_oe = oe_term;

    pld_cell_state u_state (
        .clk         (clk),
        .rst         (rst),
        .async_clear (async_clear),
        .sync_preset (sync_preset),
        .d           (or_sum),
        .q           (q)
    );

    pld_cell_out_path u_out (
        .cfg     (cfg),
        .q       (q),
        .or_sum  (or_sum),
        .pin_out (pin_out)
    );

    pld_cell_fb_path u_fb (
        .cfg    (cfg),
        .q      (q),
        .or_sum (or_sum),
        .pin_in (pin_in),
        .fb_out (fb_out)
    );

    AST_PIN_FROM_STATE: assert property (@(posedge clk) disable iff (rst)
        cfg_bits[1] |-> pin_out == (cfg_bits[0] ? q : !q)); // R5

    AST_PIN_FROM_SUM: assert property (@(posedge clk) disable iff (rst)
        !cfg_bits[1] |-> pin_out == (cfg_bits[0] ? or_sum : !or_sum)); // R6

    AST_FB_COMPAT: assert property (@(posedge clk) disable iff (rst)
        !ext_mode |-> fb_out == (cfg_bits[1] ? q : pin_in)); // R9

    AST_FB_EXT_PIN: assert property (@(posedge clk) disable iff (rst)
        (ext_mode && cfg_bits[3]) |-> fb_out == pin_in); // R8

endmodule

// File: tb/pld_io_cell_tb_top.sv
module pld_io_cell_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_mode = 1'b0;
    logic [3:0] cfg_bits = 4'd0;
    logic       or_sum = 1'b0;
    logic       oe_term = 1'b0;
    logic       sync_preset = 1'b0;
    logic       async_clear = 1'b0;
    logic       pin_in = 1'b0;
    logic       pin_out, pin_oe, fb_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic model_q = 1'b0;

    logic [2:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    pld_io_cell dut_i (
        .clk(clk), .rst(rst), .ext_mode(ext_mode), .cfg_bits(cfg_bits),
        .or_sum(or_sum), .oe_term(oe_term), .sync_preset(sync_preset),
        .async_clear(async_clear), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out)
    );

    function automatic logic [2:0] predict();
        logic sel, po, fb;
        logic [1:0] src;
        sel = cfg_bits[1] ? model_q : or_sum;
        po  = cfg_bits[0] ? sel : ~sel;
        if (ext_mode) src = cfg_bits[3:2];
        else          src = cfg_bits[1] ? 2'b00 : 2'b10;
        case (src)
            2'b00:   fb = model_q;
            2'b01:   fb = or_sum;
            default: fb = pin_in;
        endcase
        return {po, fb, oe_term};
    endfunction

    task automatic step(input logic r, input logic sum, input logic pre,
                        input logic clr, input logic pin, input logic oe,
                        input string tag);
        @(negedge clk);
        rst = r; or_sum = sum; sync_preset = pre; async_clear = clr;
        pin_in = pin; oe_term = oe;
        if (clr) model_q = 1'b0;
        exp_q.push_back(predict());
        tag_q.push_back(tag);
        @(posedge clk);
        if (clr)      model_q = 1'b0;
        else if (r)   model_q = 1'b0;
        else if (pre) model_q = 1'b1;
        else          model_q = sum;
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            #2;
            while (exp_q.size() > 0) begin
                logic [2:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if ({pin_out, fb_out, pin_oe} !== e) begin
                    failures++;
                    $display("FAIL %s cfg=%b ext=%b actual pin/fb/oe=%b expected=%b",
                             t, cfg_bits, ext_mode, {pin_out, fb_out, pin_oe}, e);
                end
            end
        end
    end

    initial begin : driver
        repeat (2) @(posedge clk);
        model_q = 1'b0;
        // reset state: R2, stored state 0, cfg 0 inverts -> pin 1
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 reset state");
        for (int m = 0; m < 2; m++) begin
            for (int c = 0; c < 16; c++) begin
                @(negedge clk);
                ext_mode = m[0];
                cfg_bits = c[3:0];
                step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R2 sync reset");
                step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R5 R6 R7 after reset");
                step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R4 load one");
                step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R4 load zero");
                step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R8 R9 load one");
                step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R3 preset over sum");
                step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R1 clear over preset");
                step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R1 after clear");
                step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R8 R9 pin vs sum");
                step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R6 R8 state zero");
            end
        end
        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : watchdog
        #(8 * 200000);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule